// File: doc/BRIEF.md
# Rotate, Shift and Bit-Manipulation Unit

This block is a purely combinational execution unit for the single-operand byte operations of an 8-bit processor core. It covers circular rotates, rotates through carry, arithmetic and logical shifts, nibble exchange, single-bit test, single-bit clear and single-bit set. The core's decoder hands it an operand byte, the current flag nibble, a two-bit operation group, a three-bit field, and a marker for the short accumulator-rotate encodings. The unit returns the new byte, the new flags and a strobe that tells the register file whether to store the byte.

The three-bit field has two meanings. In the shift/rotate group it picks the operation. In the three bit groups it is the bit index. The accumulator-rotate marker changes only one thing: in the shift/rotate group the zero flag is forced low instead of being taken from the result. Register and memory access and cycle timing are handled elsewhere in the core.

Top module: `bitops_unit`

## Requirements
- R1: With group 0, field 0 rotates left circularly (old bit 7 enters bit 0) and field 1 rotates right circularly (old bit 0 enters bit 7).
- R2: With group 0, field 2 rotates left and field 3 rotates right through carry. The incoming carry fills the vacated bit (bit 0 for left, bit 7 for right).
- R3: With group 0, field 4 shifts left and fills bit 0 with zero. Field 5 shifts right and copies bit 7 into itself. Field 7 shifts right and fills bit 7 with zero.
- R4: Flags are packed as bit 3 zero, bit 2 subtract, bit 1 half-carry and bit 0 carry, in both directions. Every group-0 operation clears subtract and half-carry. All group-0 operations except field 6 load carry with the bit shifted out: bit 7 for left moves and bit 0 for right moves.
- R5: With group 0, field 6 exchanges the upper and lower nibbles and clears carry.
- R6: In group 0 with the accumulator marker low, zero is set exactly when the result byte is 0x00.
- R7: In group 0 with the accumulator marker high, zero is always cleared.
- R8: Group 1 tests the bit picked by the field. Zero becomes the inverse of that bit, half-carry is set, subtract is cleared and carry is kept. The result equals the operand, and the write strobe is low.
- R9: Group 2 clears and group 3 sets the bit picked by the field, leaving the other bits and all four flags unchanged.
- R10: The write strobe is high for groups 0, 2 and 3.
- R11: In groups 1 to 3 the accumulator marker has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opnd | input | 8 | Operand byte |
| flagsIn | input | 4 | Current flags {zero, subtract, half-carry, carry} |
| grp | input | 2 | Operation group: 0 shift/rotate, 1 test, 2 clear, 3 set |
| sel | input | 3 | Shift/rotate operation (group 0) or bit index (groups 1 to 3) |
| accForm | input | 1 | Marks the short accumulator-rotate encoding |
| resultOut | output | 8 | Result byte |
| flagsOut | output | 4 | New flags, same packing as flagsIn |
| writeEn | output | 1 | Result byte is to be stored |

## Verification
The embedded assertions check these properties on every evaluation:
- the decode strobes are one-hot;
- the write strobe is low exactly for the test group;
- the flags pass through unchanged for bit clear and set;
- subtract and half-carry are zero after any shift;
- zero is low in the accumulator form;
- a bit test leaves the byte untouched.

The bench's scenarios are needed for the actual bit movement of each shift, which carry value falls out, which bit index is hit, and the zero flag computed from the result. These are compared against a behavioural model over all groups, fields, flag nibbles and a set of operand patterns that include 0x00, 0x80, 0x01 and 0xFF.

// File: rtl/bitops_pkg.sv
package bitops_pkg;

  localparam int FLAG_Z = 3;
  localparam int FLAG_N = 2;
  localparam int FLAG_H = 1;
  localparam int FLAG_C = 0;

  typedef enum logic [2:0] {
    SH_ROT_L   = 3'd0,
    SH_ROT_R   = 3'd1,
    SH_THRU_L  = 3'd2,
    SH_THRU_R  = 3'd3,
    SH_ARITH_L = 3'd4,
    SH_ARITH_R = 3'd5,
    SH_NIBBLE  = 3'd6,
    SH_LOGIC_R = 3'd7
  } shiftKind_t;

  typedef struct packed {
    logic       doShift;
    shiftKind_t kind;
    logic       doTest;
    logic       doClear;
    logic       doSet;
    logic       zeroForceClr;
    logic       writeBack;
  } strobes_t;

endpackage

// File: rtl/bitops_ctrl.sv
module bitops_ctrl
  import bitops_pkg::*;
#(
  parameter int SEL_W = 3
) (
  input  logic [1:0]       grp,
  input  logic [SEL_W-1:0] sel,
  input  logic             accForm,
  output strobes_t         st
);

  always_comb begin
    st = '0;
    st.kind = SH_ROT_L;
    unique case (grp)
      2'd0: begin
        st.doShift      = 1'b1;
        st.kind         = shiftKind_t'(sel[2:0]);
        st.zeroForceClr = accForm;
        st.writeBack    = 1'b1;
      end
      2'd1: st.doTest = 1'b1;
      2'd2: begin
        st.doClear   = 1'b1;
        st.writeBack = 1'b1;
      end
      default: begin
        st.doSet     = 1'b1;
        st.writeBack = 1'b1;
      end
    endcase
  end

  always_comb begin
    a_r10_one_action: assert ($onehot({st.doShift, st.doTest, st.doClear, st.doSet}));
    a_r10_store_unless_test: assert (st.writeBack == !st.doTest);
  end

endmodule

// File: rtl/bitops_dp.sv
module bitops_dp
  import bitops_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 3
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [3:0]        flagsIn,
  input  logic [SEL_W-1:0]  sel,
  input  strobes_t          st,
  output logic [DATA_W-1:0] resultOut,
  output logic [3:0]        flagsOut
);

  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] bitMask;
  logic [DATA_W-1:0] swapped;
  logic [DATA_W-1:0] shiftRes;
  logic              shiftedOut;
  logic              carryIn;

  for (genvar i = 0; i < DATA_W; i++) begin : g_mask
    assign bitMask[i] = (sel == SEL_W'(i));
  end

  assign swapped = {opnd[HALF_W-1:0], opnd[DATA_W-1:HALF_W]};
  assign carryIn = flagsIn[FLAG_C];

  always_comb begin
    shiftRes   = opnd;
    shiftedOut = 1'b0;
    unique case (st.kind)
      SH_ROT_L:   begin shiftRes = {opnd[DATA_W-2:0], opnd[DATA_W-1]}; shiftedOut = opnd[DATA_W-1]; end
      SH_ROT_R:   begin shiftRes = {opnd[0], opnd[DATA_W-1:1]};        shiftedOut = opnd[0]; end
      SH_THRU_L:  begin shiftRes = {opnd[DATA_W-2:0], carryIn};        shiftedOut = opnd[DATA_W-1]; end
      SH_THRU_R:  begin shiftRes = {carryIn, opnd[DATA_W-1:1]};        shiftedOut = opnd[0]; end
      SH_ARITH_L: begin shiftRes = {opnd[DATA_W-2:0], 1'b0};           shiftedOut = opnd[DATA_W-1]; end
      SH_ARITH_R: begin shiftRes = {opnd[DATA_W-1], opnd[DATA_W-1:1]}; shiftedOut = opnd[0]; end
      SH_NIBBLE:  begin shiftRes = swapped;                            shiftedOut = 1'b0; end
      default:    begin shiftRes = {1'b0, opnd[DATA_W-1:1]};           shiftedOut = opnd[0]; end
    endcase
  end

  always_comb begin
    resultOut = opnd;
    flagsOut  = flagsIn;
    if (st.doShift) begin
      resultOut        = shiftRes;
      flagsOut[FLAG_Z] = st.zeroForceClr ? 1'b0 : (shiftRes == '0);
      flagsOut[FLAG_N] = 1'b0;
      flagsOut[FLAG_H] = 1'b0;
      flagsOut[FLAG_C] = shiftedOut;
    end else if (st.doTest) begin
      flagsOut[FLAG_Z] = ((opnd & bitMask) == '0);
      flagsOut[FLAG_N] = 1'b0;
      flagsOut[FLAG_H] = 1'b1;
    end else if (st.doClear) begin
      resultOut = opnd & ~bitMask;
    end else if (st.doSet) begin
      resultOut = opnd | bitMask;
    end
  end

  always_comb begin
    if (st.doClear || st.doSet) begin
      a_r9_flags_kept: assert (flagsOut == flagsIn);
    end
    if (st.doTest) begin
      a_r8_test_no_change: assert (resultOut == opnd && flagsOut[FLAG_H] && flagsOut[FLAG_C] == flagsIn[FLAG_C]);
    end
    if (st.doShift) begin
      a_r4_sub_half_clear: assert (flagsOut[FLAG_N] == 1'b0 && flagsOut[FLAG_H] == 1'b0);
    end
    if (st.doShift && st.zeroForceClr) begin
      a_r7_acc_zero_low: assert (flagsOut[FLAG_Z] == 1'b0);
    end
    if (st.doShift && st.kind == SH_NIBBLE) begin
      a_r5_nibble_carry_low: assert (flagsOut[FLAG_C] == 1'b0);
    end
  end

endmodule

// File: rtl/bitops_unit.sv
module bitops_unit
  import bitops_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] opnd,
  input  logic [3:0]        flagsIn,
  input  logic [1:0]        grp,
  input  logic [SEL_W-1:0]  sel,
  input  logic              accForm,
  output logic [DATA_W-1:0] resultOut,
  output logic [3:0]        flagsOut,
  output logic              writeEn
);

  strobes_t st;

  bitops_ctrl #(.SEL_W(SEL_W)) i_ctrl (
    .grp     (grp),
    .sel     (sel),
    .accForm (accForm),
    .st      (st)
  );

  bitops_dp #(.DATA_W(DATA_W), .SEL_W(SEL_W)) i_dp (
    .opnd      (opnd),
    .flagsIn   (flagsIn),
    .sel       (sel),
    .st        (st),
    .resultOut (resultOut),
    .flagsOut  (flagsOut)
  );

  assign writeEn = st.writeBack;

  always_comb begin
    if (grp == 2'd1) begin
      a_r8_no_store_on_test: assert (!writeEn);
    end
  end

endmodule

// File: tb/test_bitops_unit.sv
module test_bitops_unit;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] opnd = '0;
  logic [3:0] flagsIn = '0;
  logic [1:0] grp = '0;
  logic [2:0] sel = '0;
  logic       accForm = 1'b0;
  logic [7:0] resultOut;
  logic [3:0] flagsOut;
  logic       writeEn;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  bitops_unit i_bitops_unit (
    .opnd(opnd), .flagsIn(flagsIn), .grp(grp), .sel(sel), .accForm(accForm),
    .resultOut(resultOut), .flagsOut(flagsOut), .writeEn(writeEn)
  );

  // Behavioural model: flags {Z,N,H,C} = bits 3..0
  task automatic model(input int op, input int fl, input int g, input int s, input int a,
                       output int res, output int fo, output int we);
    int c, z, n, h, cy, b;
    c  = fl & 1;
    z  = (fl >> 3) & 1; n = (fl >> 2) & 1; h = (fl >> 1) & 1; cy = c;
    res = op; we = 1;
    if (g == 0) begin
      case (s)
        0: begin res = ((op * 2) % 256) + op / 128;       cy = op / 128; end
        1: begin res = op / 2 + (op % 2) * 128;           cy = op % 2;   end
        2: begin res = ((op * 2) % 256) + c;              cy = op / 128; end
        3: begin res = op / 2 + c * 128;                  cy = op % 2;   end
        4: begin res = (op * 2) % 256;                    cy = op / 128; end
        5: begin res = op / 2 + (op / 128) * 128;         cy = op % 2;   end
        6: begin res = (op % 16) * 16 + op / 16;          cy = 0;        end
        default: begin res = op / 2;                      cy = op % 2;   end
      endcase
      n = 0; h = 0;
      z = (a != 0) ? 0 : ((res == 0) ? 1 : 0);
    end else begin
      b = (op >> s) & 1;
      if (g == 1) begin
        we = 0; z = (b == 0) ? 1 : 0; n = 0; h = 1;
      end else if (g == 2) begin
        if (b == 1) res = op - (1 << s);
      end else begin
        if (b == 0) res = op + (1 << s);
      end
    end
    fo = z * 8 + n * 4 + h * 2 + cy;
  endtask

  function automatic string tagFor(input int g, input int s, input int a);
    string t;
    if (g == 0) begin
      if (s < 2) t = "R1";
      else if (s < 4) t = "R2";
      else if (s == 6) t = "R5";
      else t = "R3";
      t = {t, " R4 R10 ", (a != 0) ? "R7" : "R6"};
    end else if (g == 1) t = "R8 R11";
    else t = "R9 R10 R11";
    return t;
  endfunction

  task automatic applyCheck(input int op, input int fl, input int g, input int s, input int a,
                            input string tag);
    int eRes, eFl, eWe;
    @(posedge clk);
    #1;
    opnd = 8'(op); flagsIn = 4'(fl); grp = 2'(g); sel = 3'(s); accForm = a[0];
    model(op, fl, g, s, a, eRes, eFl, eWe);
    @(negedge clk);
    checks++;
    if (int'(resultOut) != eRes || int'(flagsOut) != eFl || int'(writeEn) != eWe) begin
      errors++;
      $display("FAIL %s op=%02h fl=%01h g=%0d s=%0d a=%0d: got res=%02h fl=%01h we=%0d, expected res=%02h fl=%01h we=%0d",
               tag, op, fl, g, s, a, resultOut, flagsOut, writeEn, eRes, eFl, eWe);
    end
  endtask

  initial begin
    int pats[8] = '{8'h00, 8'h01, 8'h80, 8'hFF, 8'hA5, 8'h3C, 8'h0F, 8'h7E};
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // reset-state inputs: zero operand, group 0, field 0 -> result 0, zero flag set
    applyCheck(0, 0, 0, 0, 0, "R6 reset");
    // directed corners
    applyCheck(8'h80, 4'h0, 0, 0, 0, "R1");   // 0x01, carry 1
    applyCheck(8'h01, 4'h0, 0, 1, 1, "R7");   // 0x80, zero low
    applyCheck(8'h00, 4'h1, 0, 2, 0, "R2");   // 0x01, carry 0
    applyCheck(8'h00, 4'h1, 0, 3, 0, "R2");   // 0x80
    applyCheck(8'h81, 4'hF, 0, 5, 0, "R3");   // 0xC0, carry 1
    applyCheck(8'h81, 4'h0, 0, 7, 0, "R3");   // 0x40
    applyCheck(8'h80, 4'h0, 0, 4, 0, "R6");   // 0x00, zero set, carry set
    applyCheck(8'hF0, 4'h1, 0, 6, 0, "R5");   // 0x0F, carry cleared
    applyCheck(8'h08, 4'h1, 1, 3, 0, "R8");   // bit set -> zero low, carry kept
    applyCheck(8'hF7, 4'h0, 1, 3, 1, "R11");  // bit clear -> zero high
    applyCheck(8'hFF, 4'hA, 2, 7, 1, "R9");   // 0x7F, flags kept
    applyCheck(8'h00, 4'h5, 3, 0, 0, "R9");   // 0x01
    // sweep
    for (int g = 0; g < 4; g++)
      for (int s = 0; s < 8; s++)
        for (int a = 0; a < 2; a++)
          for (int fl = 0; fl < 16; fl++)
            for (int p = 0; p < 8; p++)
              applyCheck(pats[p], fl, g, s, a, tagFor(g, s, a));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule